// File: doc/BRIEF.md
# Supply-Loss Guard and Backup Switch Controller

This block decides, from two logic-level comparator flags, how a battery-backed
device should behave as its main supply sags and returns. One flag reports that
the supply has dropped under the power-fail threshold. The other reports that it
has dropped under the lower switchover threshold. From these flags the block
drives three registered outputs. The first blocks writes and aborts bus accesses. The second connects the backup battery. The third puts the core into its ultra-low-current mode.

Both flags are asynchronous and pass through a two-flop synchronizer. A four-state
machine (NORMAL, PROTECT, BATTERY, RECOVER) then acts on the synchronized values.
Write blocking does not end the moment the supply climbs back over the power-fail
threshold. The machine first spends a recovery interval of `REC_CYCLES` clock
cycles in RECOVER. Any new power-fail indication during that interval sends it
back to PROTECT, and the full interval starts again. Reset puts the block in
PROTECT with a full recovery count loaded, so a freshly started system must also
wait out the interval before it may write.

Top module: `pwr_guard`

## Requirements
- R1: While `rst` is high, and on the clock edge that samples it, the outputs are `wr_protect`=1, `bat_sel`=0, `low_pwr`=0. With both flags low after reset is released, `wr_protect` stays 1 for `REC_CYCLES`+2 rising edges and is 0 after the next edge.
- R2: A rise of `vlow_pf` seen from NORMAL sets `wr_protect` on the third rising edge after the change, and not before.
- R3: A rise of `vlow_sw` sets `bat_sel` and `low_pwr` on the third rising edge after the change. `wr_protect` is also 1 while the battery is selected.
- R4: A fall of `vlow_sw` clears `bat_sel` and `low_pwr` on the third rising edge after the change, and `wr_protect` stays 1.
- R5: From PROTECT, once `vlow_pf` falls with `vlow_sw` low, `wr_protect` stays 1 for `REC_CYCLES`+2 edges and clears on edge `REC_CYCLES`+3. It clears only on leaving RECOVER with the interval complete.
- R6: A rise of `vlow_pf` during the recovery interval, however short, restarts the interval in full from the next fall of `vlow_pf`.
- R7: `low_pwr` always equals `bat_sel`, and `bat_sel`=1 implies `wr_protect`=1.
- R8: When both flags fall together while the battery is selected, the block passes through PROTECT for one cycle. `wr_protect` stays 1 for `REC_CYCLES`+3 edges after the change and clears on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vlow_pf | input | 1 | Asynchronous flag: supply under the power-fail threshold |
| vlow_sw | input | 1 | Asynchronous flag: supply under the switchover threshold |
| wr_protect | output | 1 | Abort accesses and block writes |
| bat_sel | output | 1 | Connect the backup battery |
| low_pwr | output | 1 | Ultra-low-current mode enable |

## Verification
The bench targets the recovery interval's exact length. A timer that is off by one releases writes a cycle early or late, and the bench catches this. A one-cycle power-fail pulse in the middle of recovery checks the restart. A design that resumed the count, or that ignored the short pulse, would drop write protection too soon. Dropping both flags at once while on battery checks the pass through PROTECT, and so does a random mix of supply levels with hold times that straddle the interval. A design that jumped straight to NORMAL, or that left the battery selected, would show the wrong outputs.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
  typedef enum logic [1:0] {
    PG_NORMAL  = 2'd0,
    PG_PROTECT = 2'd1,
    PG_BATTERY = 2'd2,
    PG_RECOVER = 2'd3
  } pg_state_t;
endpackage

// File: rtl/pwr_guard_sync.sv
module pwr_guard_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/pwr_guard_timer.sv
module pwr_guard_timer #(
  parameter int REC_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (REC_CYCLES > 1) ? $clog2(REC_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(REC_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOAD);
  assert_hold_reload_R6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == LOAD));
endmodule

// File: rtl/pwr_guard_fsm.sv
module pwr_guard_fsm
  import pwr_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pf_s,
  input  logic      sw_s,
  input  logic      tmr_done,
  output pg_state_t st,
  output logic      wr_protect,
  output logic      bat_sel,
  output logic      low_pwr
);
  pg_state_t nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      PG_NORMAL: begin
        if (sw_s)      nxt = PG_BATTERY;
        else if (pf_s) nxt = PG_PROTECT;
      end
      PG_PROTECT: begin
        if (sw_s)       nxt = PG_BATTERY;
        else if (!pf_s) nxt = PG_RECOVER;
      end
      PG_BATTERY: begin
        if (!sw_s) nxt = PG_PROTECT;
      end
      PG_RECOVER: begin
        if (sw_s)          nxt = PG_BATTERY;
        else if (pf_s)     nxt = PG_PROTECT;
        else if (tmr_done) nxt = PG_NORMAL;
      end
      default: nxt = PG_PROTECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PG_PROTECT;
      wr_protect <= 1'b1;
      bat_sel    <= 1'b0;
      low_pwr    <= 1'b0;
    end else begin
      st         <= nxt;
      wr_protect <= (nxt != PG_NORMAL);
      bat_sel    <= (nxt == PG_BATTERY);
      low_pwr    <= (nxt == PG_BATTERY);
    end
  end

  assert_pf_protects_R2: assert property (@(posedge clk) disable iff (rst)
    pf_s |=> wr_protect);
  assert_sw_selects_bat_R3: assert property (@(posedge clk) disable iff (rst)
    sw_s |=> (bat_sel && low_pwr));
  assert_bat_exit_keeps_wp_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(bat_sel) |-> wr_protect);
  assert_release_after_recover_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_protect) |-> ($past(st) == PG_RECOVER && $past(tmr_done)));
  assert_bat_implies_wp_R7: assert property (@(posedge clk) disable iff (rst)
    (bat_sel == low_pwr) && (!bat_sel || wr_protect));
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pwr_guard_pkg::*;
#(
  parameter int REC_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic vlow_pf,
  input  logic vlow_sw,
  output logic wr_protect,
  output logic bat_sel,
  output logic low_pwr
);
  logic [1:0] flags_s;
  logic       tmr_done;
  pg_state_t  st;

  // Bit 0 (power-fail) resets asserted so the machine holds PROTECT;
  // bit 1 (switchover) resets clear so the battery is not picked at reset.
  pwr_guard_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({vlow_sw, vlow_pf}),
    .d_sync  (flags_s)
  );

  pwr_guard_timer #(.REC_CYCLES(REC_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (st == PG_RECOVER),
    .done (tmr_done)
  );

  pwr_guard_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .pf_s       (flags_s[0]),
    .sw_s       (flags_s[1]),
    .tmr_done   (tmr_done),
    .st         (st),
    .wr_protect (wr_protect),
    .bat_sel    (bat_sel),
    .low_pwr    (low_pwr)
  );
endmodule

// File: tb/pwr_guard_tb.sv
module pwr_guard_tb;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vlow_pf = 1'b0;
  logic vlow_sw = 1'b0;
  logic wr_protect, bat_sel, low_pwr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit mdl_en = 1'b0;

  always #10 clk = ~clk;

  pwr_guard #(.REC_CYCLES(N)) u_dut (
    .clk(clk), .rst(rst), .vlow_pf(vlow_pf), .vlow_sw(vlow_sw),
    .wr_protect(wr_protect), .bat_sel(bat_sel), .low_pwr(low_pwr)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic edges(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Reference model from the requirements: 0 normal, 1 protect, 2 battery, 3 recover
  logic m_p1, m_p2, m_w1, m_w2;
  int m_st, m_age;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_p1 <= 1'b1; m_p2 <= 1'b1; m_w1 <= 1'b0; m_w2 <= 1'b0;
      m_st <= 1; m_age <= 0;
    end else begin
      m_p1 <= vlow_pf; m_p2 <= m_p1;
      m_w1 <= vlow_sw; m_w2 <= m_w1;
      m_age <= (m_st == 3) ? m_age + 1 : 0;
      case (m_st)
        0: m_st <= m_w2 ? 2 : (m_p2 ? 1 : 0);
        1: m_st <= m_w2 ? 2 : (!m_p2 ? 3 : 1);
        2: m_st <= m_w2 ? 2 : 1;
        default: m_st <= m_w2 ? 2 : (m_p2 ? 1 : ((m_age == N - 1) ? 0 : 3));
      endcase
    end
  end

  always @(negedge clk) begin
    if (mdl_en) begin
      check("R5", "model wr_protect", wr_protect, (m_st != 0));
      check("R3", "model bat_sel", bat_sel, (m_st == 2));
      check("R7", "model low_pwr", low_pwr, (m_st == 2));
    end
  end

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    edges(3);
    check("R1", "reset wr_protect", wr_protect, 1'b1);
    check("R1", "reset bat_sel", bat_sel, 1'b0);
    check("R1", "reset low_pwr", low_pwr, 1'b0);
    rst = 1'b0;
    mdl_en = 1'b1;
    edges(N + 2); check("R1", "startup hold", wr_protect, 1'b1);
    edges(1);     check("R1", "startup release", wr_protect, 1'b0);

    vlow_pf = 1'b1;
    edges(2); check("R2", "pf latency early", wr_protect, 1'b0);
    edges(1); check("R2", "pf protect", wr_protect, 1'b1);

    vlow_sw = 1'b1;
    edges(2); check("R3", "battery early", bat_sel, 1'b0);
    edges(1); check("R3", "battery on", bat_sel, 1'b1);
    check("R3", "low power on", low_pwr, 1'b1);

    vlow_sw = 1'b0;
    edges(3); check("R4", "battery off", bat_sel, 1'b0);
    check("R4", "low power off", low_pwr, 1'b0);
    check("R4", "still protected", wr_protect, 1'b1);

    vlow_pf = 1'b0;
    edges(N + 2); check("R5", "recovery hold", wr_protect, 1'b1);
    edges(1);     check("R5", "recovery release", wr_protect, 1'b0);

    vlow_pf = 1'b1; edges(4);
    vlow_pf = 1'b0; edges(2 + N / 2);
    vlow_pf = 1'b1; edges(1);
    vlow_pf = 1'b0;
    edges(N + 2); check("R6", "restarted hold", wr_protect, 1'b1);
    edges(1);     check("R6", "restarted release", wr_protect, 1'b0);

    vlow_pf = 1'b1; vlow_sw = 1'b1; edges(4);
    check("R8", "battery before drop", bat_sel, 1'b1);
    vlow_pf = 1'b0; vlow_sw = 1'b0;
    edges(3);     check("R8", "battery off", bat_sel, 1'b0);
    check("R8", "protect pass", wr_protect, 1'b1);
    edges(N);     check("R8", "extended hold", wr_protect, 1'b1);
    edges(1);     check("R8", "release", wr_protect, 1'b0);

    for (int i = 0; i < 400; i++) begin
      int lvl;
      lvl = $urandom_range(0, 2);
      vlow_pf = (lvl >= 1);
      vlow_sw = (lvl == 2);
      edges($urandom_range(1, N + 6));
    end
    vlow_pf = 1'b0; vlow_sw = 1'b0;
    edges(N + 6);
    check("R5", "final release", wr_protect, 1'b0);
    finish_run();
  end
endmodule